// File: doc/BRIEF.md
# Byte-Stream Management Controller Host Transaction Engine

This block runs one complete request/response exchange with a management controller that exposes three byte registers: a data register at offset 0, a control register (write) / status register (read) at offset 1, and a flags register at offset 2. The requester first fills the request buffer one byte per cycle. It then pulses `start_i` with the request length. The engine confirms that the far side is ready and sends the request bytes. It checks the write completion code, waits for the response, and collects the response bytes into an internal buffer.

Each step is a busy-flag handshake. The engine polls the flags register until busy reads 0, reads the status, and checks it against the code it expects. It then writes the control code, writes or reads the data byte if the step has one, and writes the flags back with busy set. A wrong status, a nonzero completion code, or a step that makes no progress within the timeout restarts the exchange from its first step. After too many restarts the engine gives up and reports a hosed condition.

When the exchange ends, a done pulse reports the response length. The requester reads the formatted response through an index port. Responses that are too short or too long have byte 2 replaced by a completion code.

Top module: `smic_host_ctrl`

## Requirements
- R1: The engine makes at most one register access per cycle, using offset 0 for data, 1 for control/status and 2 for flags. It makes no access in the hosed state.
- R2: A status read happens only in the cycle after a flags read that showed bit 0 (busy) clear. Flags bits 4 and 3 have no effect on the exchange.
- R3: Every step writes its control code first, then the data byte if the step has one, and last the flags value read for that step with bit 0 set.
- R4: The write phase follows this order. Get-status 0x40 must return status 0xC0. Write-start 0x41 carries byte 0. Each later byte waits for flags bit 6 (transmit ready) and goes out with 0x42, or with 0x43 for the last byte. Each status must equal the previous code with bit 7 set. After 0x43 the data register must read 0x00.
- R5: The read phase follows this order. The engine waits for flags bit 7 (receive ready) and issues read-start 0x44. Once status 0xC4 is seen with receive ready set, it captures a byte and issues 0x45. Status 0xC5 continues the read, after receive ready. Status 0xC6 means capture the final byte and issue 0x46. The engine then requires status 0xC0 and data 0x00.
- R6: A start is accepted only in the idle or hosed state and only for a length from MIN_LEN (2) to MAX_LEN (80). Otherwise `reject_o` pulses in the next cycle and the exchange in progress is unaffected.
- R7: A wrong status or a nonzero completion code restarts the exchange from get-status. The MAX_RETRY+1-th consecutive failure (4 by default) raises `hosed_o` for one cycle instead of restarting.
- R8: A step with no progress for TIMEOUT_MS milliseconds of CLK_HZ cycles counts as a failure under R7. The timer reloads on every step that goes ahead, so long exchanges never time out.
- R9: Response bytes beyond MAX_LEN are read and dropped. The reported length is then MAX_LEN and response byte 2 reads CC_TRUNC (0xCE).
- R10: A response shorter than 3 bytes is reported with length 3, and byte 2 reads CC_UNSPEC (0xFF).
- R11: On success `done_o` pulses for one cycle, in the cycle after the final zero data read. `rsp_len_o` and `rsp_byte_o` hold the result until the next start.
- R12: In the idle state, `attn_o` follows flags bit 2 (message available) from the last flags read that showed busy clear. It is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_we_i | input | 1 | Write one request byte (idle or hosed only) |
| req_idx_i | input | AW | Request byte index |
| req_byte_i | input | 8 | Request byte value |
| req_len_i | input | LW | Request length, sampled with start_i |
| start_i | input | 1 | Start an exchange |
| reject_o | output | 1 | Start refused (one cycle) |
| done_o | output | 1 | Exchange completed (one cycle) |
| hosed_o | output | 1 | Exchange abandoned (one cycle) |
| attn_o | output | 1 | Message waiting at the far side |
| rsp_len_o | output | LW | Formatted response length |
| rsp_idx_i | input | AW | Response byte index |
| rsp_byte_o | output | 8 | Formatted response byte |
| reg_addr_o | output | 2 | Register offset |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the strobe cycle |

## Verification
A behavioural far-side model answers every code and holds busy for a few cycles after each flags write. It always drives flags bits 4 and 3 high. Table vectors sweep request lengths from 2 to 80 and response lengths of 2, 3, 5, 80 and 83. This separates plain collection from 3-byte padding and from truncation, and it separates the write-start-only path from long write-next runs. Directed cases inject a wrong ready status, a failing write or read completion code, and a permanently busy far side. These show whether the engine retries from the first step, counts failures correctly up to the hosed limit, and times out. Further cases check refused starts, starts during an exchange, and the attention flag in idle.

// File: rtl/smic_pkg.sv
package smic_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START_OP, ST_OP_OK, ST_WR, ST_WR_END,
    ST_W2R, ST_RD_START, ST_RD_NEXT, ST_RD_END, ST_HOSED
  } smic_st_e;

  typedef enum logic [1:0] {PH_FLG, PH_STS, PH_OPS} smic_ph_e;

  localparam logic [1:0] A_DATA  = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_FLAGS = 2'd2;

  localparam int F_RX  = 7;
  localparam int F_TX  = 6;
  localparam int F_MSG = 2;
  localparam int F_BSY = 0;

  localparam logic [7:0] C_GET    = 8'h40;
  localparam logic [7:0] C_WSTART = 8'h41;
  localparam logic [7:0] C_WNEXT  = 8'h42;
  localparam logic [7:0] C_WEND   = 8'h43;
  localparam logic [7:0] C_RSTART = 8'h44;
  localparam logic [7:0] C_RNEXT  = 8'h45;
  localparam logic [7:0] C_REND   = 8'h46;

  function automatic logic [7:0] sts_of(input logic [7:0] code);
    return code | 8'h80;
  endfunction
endpackage

// File: rtl/smic_byte_ram.sv
module smic_byte_ram #(
  parameter int DEPTH = 80,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && int'(waddr_i) < DEPTH) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem[raddr_i] : 8'h00;
endmodule

// File: rtl/smic_wdog.sv
module smic_wdog #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic reload_i,
  output logic expire_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt <= '0;
    else if (!run_i || reload_i) cnt <= '0;
    else if (cnt != CW'(LIMIT))  cnt <= cnt + 1'b1;
  end

  assign expire_o = run_i && (cnt == CW'(LIMIT));
endmodule

// File: rtl/smic_result_fmt.sv
module smic_result_fmt #(
  parameter int MAX_LEN = 80,
  parameter logic [7:0] CC_UNSPEC = 8'hFF,
  parameter logic [7:0] CC_TRUNC  = 8'hCE,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 2)
) (
  input  logic [LW-1:0] rpos_i,
  input  logic          trunc_i,
  input  logic [AW-1:0] idx_i,
  input  logic [7:0]    raw_i,
  output logic [LW-1:0] len_o,
  output logic [7:0]    byte_o
);
  logic short_rsp;
  assign short_rsp = rpos_i < LW'(3);
  assign len_o     = short_rsp ? LW'(3) : rpos_i;

  always_comb begin
    if (idx_i == AW'(2) && trunc_i)        byte_o = CC_TRUNC;
    else if (idx_i == AW'(2) && short_rsp) byte_o = CC_UNSPEC;
    else if (int'(idx_i) < int'(rpos_i))   byte_o = raw_i;
    else                                   byte_o = 8'h00;
  end
endmodule

// File: rtl/smic_host_ctrl.sv
module smic_host_ctrl
  import smic_pkg::*;
#(
  parameter int MAX_LEN    = 80,
  parameter int MIN_LEN    = 2,
  parameter int MAX_RETRY  = 3,
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIMEOUT_MS = 2000,
  parameter logic [7:0] CC_UNSPEC = 8'hFF,
  parameter logic [7:0] CC_TRUNC  = 8'hCE,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_idx_i,
  input  logic [7:0]    req_byte_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          start_i,
  output logic          reject_o,
  output logic          done_o,
  output logic          hosed_o,
  output logic          attn_o,
  output logic [LW-1:0] rsp_len_o,
  input  logic [AW-1:0] rsp_idx_i,
  output logic [7:0]    rsp_byte_o,
  output logic [1:0]    reg_addr_o,
  output logic          reg_rd_o,
  output logic          reg_wr_o,
  output logic [7:0]    reg_wdata_o,
  input  logic [7:0]    reg_rdata_i
);
  localparam int TO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int RW     = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  smic_st_e      state;
  smic_ph_e      ph;
  logic [7:0]    flg_q, ctrl_q, wd_q, wr_byte, rsp_raw;
  logic [LW-1:0] wpos, rpos, len_q;
  logic [RW-1:0] retries;
  logic          trunc_q;
  logic          op_rd, op_chk, op_ctrl, op_wd, op_bsy;

  logic          can_start, len_ok, accept, run, err, expire, cap_we;
  logic          d_go, d_err, d_rd, d_chk, d_ctrl, d_wd, d_bsy;
  logic [7:0]    d_code;
  smic_st_e      d_state;

  assign can_start = (state == ST_IDLE) || (state == ST_HOSED);
  assign len_ok    = (req_len_i >= LW'(MIN_LEN)) && (req_len_i <= LW'(MAX_LEN));
  assign accept    = start_i && can_start && len_ok;
  assign run       = !can_start;

  smic_byte_ram #(.DEPTH(MAX_LEN)) u_req (
    .clk_i, .we_i(req_we_i && can_start), .waddr_i(req_idx_i), .wdata_i(req_byte_i),
    .raddr_i(wpos[AW-1:0]), .rdata_o(wr_byte));

  assign cap_we = (ph == PH_OPS) && op_rd && !op_chk && (rpos < LW'(MAX_LEN));

  smic_byte_ram #(.DEPTH(MAX_LEN)) u_rsp (
    .clk_i, .we_i(cap_we), .waddr_i(rpos[AW-1:0]), .wdata_i(reg_rdata_i),
    .raddr_i(rsp_idx_i), .rdata_o(rsp_raw));

  smic_result_fmt #(.MAX_LEN(MAX_LEN), .CC_UNSPEC(CC_UNSPEC), .CC_TRUNC(CC_TRUNC)) u_fmt (
    .rpos_i(rpos), .trunc_i(trunc_q), .idx_i(rsp_idx_i), .raw_i(rsp_raw),
    .len_o(rsp_len_o), .byte_o(rsp_byte_o));

  smic_wdog #(.LIMIT(TO_CYC)) u_wdog (
    .clk_i, .rst_ni, .run_i(run),
    .reload_i(accept || err || (ph == PH_STS && d_go)), .expire_o(expire));

  // Step decision: status on reg_rdata_i, flags latched in flg_q
  always_comb begin
    logic last;
    logic [7:0] sts;
    sts  = reg_rdata_i;
    last = (wpos == len_q - LW'(1));
    d_go = 1'b0; d_err = 1'b0; d_rd = 1'b0; d_chk = 1'b0;
    d_ctrl = 1'b0; d_wd = 1'b0; d_bsy = 1'b0; d_code = C_GET; d_state = state;
    case (state)
      ST_START_OP: begin
        d_go = 1'b1; d_ctrl = 1'b1; d_bsy = 1'b1; d_code = C_GET; d_state = ST_OP_OK;
      end
      ST_OP_OK:
        if (sts != sts_of(C_GET)) d_err = 1'b1;
        else begin
          d_go = 1'b1; d_ctrl = 1'b1; d_wd = 1'b1; d_bsy = 1'b1;
          d_code = C_WSTART; d_state = ST_WR;
        end
      ST_WR:
        if (sts != ((wpos == LW'(1)) ? sts_of(C_WSTART) : sts_of(C_WNEXT))) d_err = 1'b1;
        else if (flg_q[F_TX]) begin
          d_go = 1'b1; d_ctrl = 1'b1; d_wd = 1'b1; d_bsy = 1'b1;
          d_code  = last ? C_WEND : C_WNEXT;
          d_state = last ? ST_WR_END : ST_WR;
        end
      ST_WR_END:
        if (sts != sts_of(C_WEND)) d_err = 1'b1;
        else begin d_go = 1'b1; d_rd = 1'b1; d_chk = 1'b1; end
      ST_W2R:
        if (flg_q[F_RX]) begin
          d_go = 1'b1; d_ctrl = 1'b1; d_bsy = 1'b1; d_code = C_RSTART; d_state = ST_RD_START;
        end
      ST_RD_START:
        if (sts != sts_of(C_RSTART)) d_err = 1'b1;
        else if (flg_q[F_RX]) begin
          d_go = 1'b1; d_rd = 1'b1; d_ctrl = 1'b1; d_bsy = 1'b1;
          d_code = C_RNEXT; d_state = ST_RD_NEXT;
        end
      ST_RD_NEXT:
        if (sts == sts_of(C_REND)) begin
          d_go = 1'b1; d_rd = 1'b1; d_ctrl = 1'b1; d_bsy = 1'b1;
          d_code = C_REND; d_state = ST_RD_END;
        end else if (sts == sts_of(C_RNEXT)) begin
          if (flg_q[F_RX]) begin
            d_go = 1'b1; d_rd = 1'b1; d_ctrl = 1'b1; d_bsy = 1'b1; d_code = C_RNEXT;
          end
        end else d_err = 1'b1;
      ST_RD_END:
        if (sts != sts_of(C_GET)) d_err = 1'b1;
        else begin d_go = 1'b1; d_rd = 1'b1; d_chk = 1'b1; end
      default: ;
    endcase
  end

  assign err = run && (expire || (ph == PH_STS && d_err) ||
                       (ph == PH_OPS && op_rd && op_chk && reg_rdata_i != 8'h00));

  // Register bus: rd > ctrl > data > flags gives both step orders
  always_comb begin
    reg_rd_o = 1'b0; reg_wr_o = 1'b0; reg_addr_o = A_FLAGS; reg_wdata_o = 8'h00;
    case (ph)
      PH_FLG: reg_rd_o = (state != ST_HOSED);
      PH_STS: begin reg_rd_o = 1'b1; reg_addr_o = A_CTRL; end
      PH_OPS:
        if (op_rd) begin reg_rd_o = 1'b1; reg_addr_o = A_DATA; end
        else if (op_ctrl) begin reg_wr_o = 1'b1; reg_addr_o = A_CTRL; reg_wdata_o = ctrl_q; end
        else if (op_wd) begin reg_wr_o = 1'b1; reg_addr_o = A_DATA; reg_wdata_o = wd_q; end
        else if (op_bsy) begin reg_wr_o = 1'b1; reg_wdata_o = flg_q | 8'h01; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; ph <= PH_FLG; flg_q <= '0; ctrl_q <= '0; wd_q <= '0;
      wpos <= '0; rpos <= '0; len_q <= '0; retries <= '0; trunc_q <= 1'b0;
      op_rd <= 1'b0; op_chk <= 1'b0; op_ctrl <= 1'b0; op_wd <= 1'b0; op_bsy <= 1'b0;
      reject_o <= 1'b0; done_o <= 1'b0; hosed_o <= 1'b0; attn_o <= 1'b0;
    end else begin
      reject_o <= start_i && !accept;
      done_o   <= 1'b0;
      hosed_o  <= 1'b0;
      if (accept) begin
        state <= ST_START_OP; ph <= PH_FLG; len_q <= req_len_i; retries <= '0;
        wpos <= '0; rpos <= '0; trunc_q <= 1'b0; attn_o <= 1'b0;
        {op_rd, op_chk, op_ctrl, op_wd, op_bsy} <= '0;
      end else if (err) begin
        ph <= PH_FLG;
        {op_rd, op_chk, op_ctrl, op_wd, op_bsy} <= '0;
        if (retries == RW'(MAX_RETRY)) begin
          state <= ST_HOSED; hosed_o <= 1'b1;
        end else begin
          retries <= retries + 1'b1; state <= ST_START_OP;
          wpos <= '0; rpos <= '0; trunc_q <= 1'b0;
        end
      end else begin
        case (ph)
          PH_FLG:
            if (state == ST_IDLE) begin
              if (!reg_rdata_i[F_BSY]) attn_o <= reg_rdata_i[F_MSG];
            end else if (state != ST_HOSED && !reg_rdata_i[F_BSY]) begin
              flg_q <= reg_rdata_i; ph <= PH_STS;
            end
          PH_STS:
            if (d_go) begin
              op_rd <= d_rd; op_chk <= d_chk; op_ctrl <= d_ctrl; op_wd <= d_wd; op_bsy <= d_bsy;
              ctrl_q <= d_code; wd_q <= wr_byte; state <= d_state; ph <= PH_OPS;
              if (d_wd) wpos <= wpos + 1'b1;
            end else ph <= PH_FLG;
          PH_OPS: begin
            if (op_rd) begin
              op_rd <= 1'b0;
              if (op_chk) begin
                op_chk <= 1'b0;
                if (state == ST_WR_END) state <= ST_W2R;
                else begin state <= ST_IDLE; done_o <= 1'b1; end
              end else if (rpos == LW'(MAX_LEN)) trunc_q <= 1'b1;
              else rpos <= rpos + 1'b1;
            end else if (op_ctrl) op_ctrl <= 1'b0;
            else if (op_wd) op_wd <= 1'b0;
            else op_bsy <= 1'b0;
            if ($onehot({op_rd, op_ctrl, op_wd, op_bsy})) ph <= PH_FLG;
          end
          default: ph <= PH_FLG;
        endcase
      end
    end
  end

  a_r1_one_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));
  a_r1_quiet_hosed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HOSED && !start_i) |=> !(reg_rd_o || reg_wr_o));
  a_r2_busy_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_o && reg_addr_o == A_CTRL) |->
      $past(reg_rd_o && reg_addr_o == A_FLAGS && !reg_rdata_i[F_BSY]));
  a_r7_hosed_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hosed_o |-> (state == ST_HOSED));
  a_r9_rpos_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpos <= LW'(MAX_LEN));
  a_r11_done_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(reg_rd_o && reg_addr_o == A_DATA && reg_rdata_i == 8'h00));
  a_r11_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && hosed_o));
  a_r12_attn_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_o |-> (state == ST_IDLE));
endmodule

// File: tb/tb_smic_host_ctrl.sv
`timescale 1ns/1ps
module tb_smic_host_ctrl;
  localparam int MAXL = 80;
  localparam int AW = $clog2(MAXL);
  localparam int LW = $clog2(MAXL + 2);
  localparam int TO = 100;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_we_i = 1'b0, start_i = 1'b0;
  logic [AW-1:0] req_idx_i = '0, rsp_idx_i = '0;
  logic [7:0] req_byte_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic reject_o, done_o, hosed_o, attn_o, reg_rd_o, reg_wr_o;
  logic [LW-1:0] rsp_len_o;
  logic [7:0] rsp_byte_o, reg_wdata_o, reg_rdata_i;
  logic [1:0] reg_addr_o;

  always #5 clk = ~clk;

  smic_host_ctrl #(.MAX_LEN(MAXL), .CLK_HZ(100_000), .TIMEOUT_MS(1)) dut (
    .clk_i(clk), .rst_ni, .req_we_i, .req_idx_i, .req_byte_i, .req_len_i, .start_i,
    .reject_o, .done_o, .hosed_o, .attn_o, .rsp_len_o, .rsp_idx_i, .rsp_byte_o,
    .reg_addr_o, .reg_rd_o, .reg_wr_o, .reg_wdata_o, .reg_rdata_i);

  // far-side model
  logic m_busy = 0, m_rx = 0, m_msg = 0, stall = 0, ctrl_seen = 0;
  logic [7:0] m_sts = 8'hC0, m_data = 0, m_code = 0, m_wbyte = 0;
  int m_cnt = 0, ridx = 0, rsp_len = 2, rseed = 0, tx_n = 0;
  int inj_ready = 0, inj_wcc = 0, inj_rcc = 0;
  int n_get = 0, n_wstart = 0, order_err = 0;
  logic [7:0] tx_log [128];
  logic [7:0] m_flags;

  function automatic logic [7:0] rbyte(input int i, input int s);
    return 8'((i * 7 + s) & 255);
  endfunction
  function automatic logic [7:0] qbyte(input int i, input int s);
    return 8'((i * 13 + s * 3) & 255);
  endfunction

  assign m_flags = {m_rx, 1'b1, 1'b0, 2'b11, m_msg, 1'b0, m_busy};
  assign reg_rdata_i = (reg_addr_o == 2'd0) ? m_data : (reg_addr_o == 2'd1) ? m_sts : m_flags;

  always @(posedge clk) begin
    if (reg_wr_o && reg_addr_o == 2'd1) begin m_code <= reg_wdata_o; ctrl_seen <= 1; end
    if (reg_wr_o && reg_addr_o == 2'd0) begin
      if (!ctrl_seen) order_err <= order_err + 1;
      m_wbyte <= reg_wdata_o;
    end
    if (reg_wr_o && reg_addr_o == 2'd2 && reg_wdata_o[0]) begin
      if (!ctrl_seen) order_err <= order_err + 1;
      ctrl_seen <= 0; m_busy <= 1; m_cnt <= 2;
    end else if (m_busy && !stall) begin
      if (m_cnt > 0) m_cnt <= m_cnt - 1;
      else begin
        m_busy <= 0;
        case (m_code)
          8'h40: begin
            n_get <= n_get + 1; m_rx <= 0;
            if (inj_ready > 0) begin inj_ready <= inj_ready - 1; m_sts <= 8'hC5; end
            else m_sts <= 8'hC0;
          end
          8'h41: begin tx_log[0] <= m_wbyte; tx_n <= 1; m_sts <= 8'hC1; n_wstart <= n_wstart + 1; end
          8'h42: begin tx_log[tx_n] <= m_wbyte; tx_n <= tx_n + 1; m_sts <= 8'hC2; end
          8'h43: begin
            tx_log[tx_n] <= m_wbyte; tx_n <= tx_n + 1; m_sts <= 8'hC3; m_rx <= 1;
            if (inj_wcc > 0) begin inj_wcc <= inj_wcc - 1; m_data <= 8'h81; end
            else m_data <= 8'h00;
          end
          8'h44: begin ridx <= 0; m_data <= rbyte(0, rseed); m_sts <= 8'hC4; end
          8'h45: begin
            ridx <= ridx + 1; m_data <= rbyte(ridx + 1, rseed);
            m_sts <= (ridx + 1 == rsp_len - 1) ? 8'hC6 : 8'hC5;
          end
          8'h46: begin
            m_sts <= 8'hC0; m_rx <= 0;
            if (inj_rcc > 0) begin inj_rcc <= inj_rcc - 1; m_data <= 8'h22; end
            else m_data <= 8'h00;
          end
          default: m_sts <= 8'hC0;
        endcase
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic load_req(input int len, input int s);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      req_we_i = 1; req_idx_i = AW'(i); req_byte_i = qbyte(i, s);
    end
    @(negedge clk); req_we_i = 0;
  endtask

  task automatic pulse_start(input int len, output bit rej);
    @(negedge clk); req_len_i = LW'(len); start_i = 1;
    @(negedge clk); start_i = 0; rej = reject_o;
  endtask

  task automatic wait_end(input int maxc, output bit d, output bit h, output int cyc);
    d = 0; h = 0; cyc = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk); cyc = i + 1;
      if (done_o) begin d = 1; break; end
      if (hosed_o) begin h = 1; break; end
    end
  endtask

  task automatic rsp_at(input int idx, output logic [7:0] b);
    rsp_idx_i = AW'(idx); #1; b = rsp_byte_o;
  endtask

  task automatic run_full(input int ql, input int rl, input int s, input string tag);
    bit rej, d, h; int cyc, bad, g0, e0, n; logic [7:0] b, e2;
    load_req(ql, s);
    rseed = s; rsp_len = rl; g0 = n_get; e0 = order_err;
    pulse_start(ql, rej);
    wait_end(5000, d, h, cyc);
    chk(d && !rej, {tag, " R11 done pulse"}, d, 1);
    chk(n_get - g0 == 1, {tag, " R8 no retry on progress"}, n_get - g0, 1);
    chk(tx_n == ql, {tag, " R1 R4 request byte count"}, tx_n, ql);
    bad = 0;
    for (int i = 0; i < ql; i++) if (tx_log[i] !== qbyte(i, s)) bad++;
    chk(bad == 0, {tag, " R4 request bytes"}, bad, 0);
    chk(order_err == e0, {tag, " R3 step write order"}, order_err - e0, 0);
    n = (rl > MAXL) ? MAXL : rl;
    chk(int'(rsp_len_o) == ((n < 3) ? 3 : n), {tag, " R9 R10 R11 length"}, rsp_len_o, (n < 3) ? 3 : n);
    bad = 0;
    for (int i = 0; i < n; i++) if (i != 2) begin
      rsp_at(i, b); if (b !== rbyte(i, s)) bad++;
    end
    chk(bad == 0, {tag, " R2 R5 response bytes"}, bad, 0);
    e2 = (rl > MAXL) ? 8'hCE : (rl < 3) ? 8'hFF : rbyte(2, s);
    rsp_at(2, b);
    chk(b == e2, {tag, " R9 R10 byte 2"}, b, e2);
  endtask

  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{2, 2, 11}, '{3, 5, 22}, '{80, 4, 33}, '{6, 80, 44}, '{5, 83, 55}, '{12, 3, 66}};

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit rej, d, h; int cyc, g0, w0;
    repeat (3) @(negedge clk);
    chk(!done_o && !hosed_o && !reject_o, "R11 reset outputs quiet", done_o | hosed_o, 0);
    chk(!attn_o && !reg_wr_o, "R12 R1 reset attn and bus", attn_o | reg_wr_o, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) run_full(VEC[v][0], VEC[v][1], VEC[v][2], $sformatf("vec%0d", v));

    // R12 attention in idle
    m_msg = 1; repeat (4) @(negedge clk);
    chk(attn_o == 1, "R12 attn set in idle", attn_o, 1);
    m_msg = 0; repeat (4) @(negedge clk);
    chk(attn_o == 0, "R12 attn cleared", attn_o, 0);

    // R6 length limits and busy start
    pulse_start(1, rej);  chk(rej, "R6 reject length 1", rej, 1);
    pulse_start(81, rej); chk(rej, "R6 reject length 81", rej, 1);
    load_req(10, 7); rseed = 7; rsp_len = 6;
    pulse_start(10, rej); chk(!rej, "R6 accept length 10", rej, 0);
    repeat (20) @(negedge clk);
    pulse_start(4, rej);  chk(rej, "R6 reject start while active", rej, 1);
    wait_end(5000, d, h, cyc);
    chk(d && tx_n == 10, "R6 active exchange unaffected", tx_n, 10);

    // R7 bad ready status, recovered
    g0 = n_get; inj_ready = 2;
    pulse_start(4, rej); wait_end(5000, d, h, cyc);
    chk(d, "R7 done after two retries", d, 1);
    chk(n_get - g0 == 3, "R7 get-status count", n_get - g0, 3);

    // R4 write completion failure
    w0 = n_wstart; inj_wcc = 1;
    pulse_start(4, rej); wait_end(5000, d, h, cyc);
    chk(d && n_wstart - w0 == 2, "R4 R7 restart on write code", n_wstart - w0, 2);
    chk(tx_n == 4 && tx_log[3] == qbyte(3, 7), "R4 resent request intact", tx_n, 4);

    // R5 read completion failure
    g0 = n_get; inj_rcc = 1;
    pulse_start(4, rej); wait_end(5000, d, h, cyc);
    chk(d && n_get - g0 == 2, "R5 R7 restart on read code", n_get - g0, 2);

    // R7 hosed after limit
    g0 = n_get; inj_ready = 4;
    pulse_start(4, rej); wait_end(5000, d, h, cyc);
    chk(h && !d, "R7 hosed after four failures", h, 1);
    chk(n_get - g0 == 4, "R7 attempts before hosed", n_get - g0, 4);
    repeat (5) @(negedge clk);
    pulse_start(4, rej); wait_end(5000, d, h, cyc);
    chk(!rej && d, "R6 start accepted from hosed", d, 1);

    // R8 timeout
    stall = 1;
    pulse_start(4, rej); wait_end(5000, d, h, cyc);
    chk(h, "R8 hosed on stalled far side", h, 1);
    chk(cyc >= 4 * TO && cyc <= 4 * TO + 80, "R8 timeout window", cyc, 4 * TO);
    stall = 0; repeat (10) @(negedge clk);
    run_full(9, 7, 77, "post");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule